// File: doc/BRIEF.md
# Preset Down Counter with Zero Output

This block counts events downward from a loaded preset. It reloads its signed present value from a preset input when the chip comes out of reset and whenever a clear request is recognised. After that, every rising edge on the count input lowers the value by one. The output turns on when a count edge takes the value from one to zero. Counting carries on below zero and stops at the most negative value the register can hold.

The output has two behaviours. In held mode it stays on until the next recognised clear. In timed mode it stays on for a programmed number of tick-enable cycles. A clear request must stay high for a programmable number of clock cycles before it takes effect. While the clear input is high, count edges are ignored, and counting starts again once it falls. All inputs are taken to be synchronous to the clock.

Top module: `preset_down_counter`

## Requirements
- R1: Each 0-to-1 transition of `cnt_in`, sampled on consecutive clock edges while `clr_in` is low, lowers `pv` by exactly one at that edge. A level held high gives no further decrements.
- R2: `out_on` rises on the same clock edge at which a count edge moves `pv` from 1 to 0.
- R3: Further count edges after zero keep lowering `pv` into negative values. The output state is not affected by them.
- R4: A recognised clear reloads `pv` with `preset_val` (zero-extended) and turns `out_on` off, both on the edge where the clear is recognised.
- R5: While `clr_in` is high, count edges leave `pv` unchanged. A `cnt_in` rise that happened while `clr_in` was high is not counted after `clr_in` falls. The next fresh rise after `clr_in` is low is counted.
- R6: A clear is recognised on the edge where `clr_in` has been sampled high on `clr_min_len` consecutive edges, with 0 treated as 1. A shorter high level changes neither `pv` nor `out_on`.
- R7: `pv` saturates at -2^SV_W. A count edge at that value leaves it there.
- R8: The output fires only on a 1-to-0 transition, so a preset of 0 never fires it. It fires at most once per reload: after a timed pulse ends, more count edges do not restart it.
- R9: With `latch_mode`=1, or with `pulse_len`=0, `out_on` stays high until a recognised clear. With `latch_mode`=0 and `pulse_len`=N>0, `out_on` falls on the edge that samples the N-th high `tick_en` after the edge where it rose.
- R10: While `rst` is high, `pv` equals `preset_val` at each edge, `out_on` is low and any partly counted clear is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Time base for timed output pulses |
| cnt_in | input | 1 | Count input; each rising edge decrements |
| clr_in | input | 1 | Clear request, level held; inhibits counting |
| preset_val | input | SV_W | Value loaded into the counter |
| latch_mode | input | 1 | 1 = held output, 0 = timed output |
| pulse_len | input | PW_W | Timed pulse length in ticks |
| clr_min_len | input | CW_W | Minimum clear width in clock cycles |
| pv | output | SV_W+1 | Signed present value |
| out_on | output | 1 | Zero-reached output |

## Verification
The assertions check the following on every cycle: the single-step decrement, saturation at the floor, the output rising with the 1-to-0 step and only at zero, the value holding or reloading while a clear is high, and the reload-and-clear effect of a recognised clear. Some behaviours need stimulus over many cycles and can only be shown by the bench scenarios. These are the exact width threshold of the clear qualifier, the rule that a stale count edge is not counted after a clear, the length of a timed pulse in ticks, and the absence of a second firing. The bench also sweeps every preset value of a narrow configuration down to saturation.

// File: rtl/pdc_pkg.sv
package pdc_pkg;

    typedef enum logic [1:0] {
        OS_OFF   = 2'd0,
        OS_TIMED = 2'd1,
        OS_HELD  = 2'd2
    } out_state_e;

    typedef struct packed {
        logic count;
        logic clear;
        logic zero;
    } pdc_evt_t;

    function automatic logic rise_of(input logic now_v, input logic prev_v);
        return now_v & ~prev_v;
    endfunction

endpackage

// File: rtl/pdc_edge.sv
module pdc_edge
    import pdc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic sig_in,
    output logic rise
);
    logic prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= sig_in;
    end

    assign rise = rise_of(sig_in, prev_q);
endmodule

// File: rtl/pdc_clr_qual.sv
module pdc_clr_qual #(
    parameter int CW_W = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            clr_in,
    input  logic [CW_W-1:0] min_len,
    output logic            clr_evt
);
    localparam logic [CW_W-1:0] HCNT_MAX = '1;

    logic [CW_W-1:0] hcnt_q;
    logic            done_q;
    logic [CW_W:0]   seen;
    logic [CW_W:0]   need;

    assign seen    = {1'b0, hcnt_q} + 1'b1;
    assign need    = (min_len == '0) ? (CW_W+1)'(1) : {1'b0, min_len};
    assign clr_evt = clr_in && !done_q && (seen >= need);

    always_ff @(posedge clk) begin
        if (rst || !clr_in) begin
            hcnt_q <= '0;
            done_q <= 1'b0;
        end else begin
            if (hcnt_q != HCNT_MAX) hcnt_q <= hcnt_q + 1'b1;
            if (clr_evt)            done_q <= 1'b1;
        end
    end
endmodule

// File: rtl/pdc_pv_core.sv
module pdc_pv_core #(
    parameter int SV_W = 8,
    localparam int PV_W = SV_W + 1
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   cnt_evt,
    input  logic                   clr_evt,
    input  logic [SV_W-1:0]        preset,
    output logic signed [PV_W-1:0] pv,
    output logic                   zero_evt
);
    localparam logic signed [PV_W-1:0] PV_MIN = {1'b1, {SV_W{1'b0}}};
    localparam logic signed [PV_W-1:0] PV_ONE = PV_W'(1);

    logic signed [PV_W-1:0] pv_q;

    always_ff @(posedge clk) begin
        if (rst || clr_evt) begin
            pv_q <= signed'({1'b0, preset});
        end else if (cnt_evt && (pv_q != PV_MIN)) begin
            pv_q <= pv_q - PV_ONE;
        end
    end

    assign zero_evt = cnt_evt && !clr_evt && (pv_q == PV_ONE);
    assign pv       = pv_q;
endmodule

// File: rtl/pdc_out_shaper.sv
module pdc_out_shaper
    import pdc_pkg::*;
#(
    parameter int PW_W = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  pdc_evt_t        evt,
    input  logic            tick_en,
    input  logic            latch_mode,
    input  logic [PW_W-1:0] pulse_len,
    output logic            out_on
);
    out_state_e      st_q;
    logic [PW_W-1:0] rem_q;

    always_ff @(posedge clk) begin
        if (rst || evt.clear) begin
            st_q  <= OS_OFF;
            rem_q <= '0;
        end else if (evt.zero) begin
            if (latch_mode || pulse_len == '0) begin
                st_q <= OS_HELD;
            end else begin
                st_q  <= OS_TIMED;
                rem_q <= pulse_len;
            end
        end else if (st_q == OS_TIMED && tick_en) begin
            if (rem_q <= PW_W'(1)) st_q <= OS_OFF;
            else                   rem_q <= rem_q - 1'b1;
        end
    end

    assign out_on = (st_q != OS_OFF);
endmodule

// File: rtl/preset_down_counter.sv
module preset_down_counter
    import pdc_pkg::*;
#(
    parameter int SV_W = 8,
    parameter int PW_W = 8,
    parameter int CW_W = 4,
    localparam int PV_W = SV_W + 1
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   tick_en,
    input  logic                   cnt_in,
    input  logic                   clr_in,
    input  logic [SV_W-1:0]        preset_val,
    input  logic                   latch_mode,
    input  logic [PW_W-1:0]        pulse_len,
    input  logic [CW_W-1:0]        clr_min_len,
    output logic signed [PV_W-1:0] pv,
    output logic                   out_on
);
    logic     cnt_rise;
    logic     clr_evt;
    logic     zero_evt;
    pdc_evt_t evt;

    pdc_edge u_edge (
        .clk    (clk),
        .rst    (rst),
        .sig_in (cnt_in),
        .rise   (cnt_rise)
    );

    pdc_clr_qual #(.CW_W(CW_W)) u_qual (
        .clk     (clk),
        .rst     (rst),
        .clr_in  (clr_in),
        .min_len (clr_min_len),
        .clr_evt (clr_evt)
    );

    pdc_pv_core #(.SV_W(SV_W)) u_core (
        .clk      (clk),
        .rst      (rst),
        .cnt_evt  (evt.count),
        .clr_evt  (clr_evt),
        .preset   (preset_val),
        .pv       (pv),
        .zero_evt (zero_evt)
    );

    always_comb begin
        evt.count = cnt_rise && !clr_in;
        evt.clear = clr_evt;
        evt.zero  = zero_evt;
    end

    pdc_out_shaper #(.PW_W(PW_W)) u_out (
        .clk        (clk),
        .rst        (rst),
        .evt        (evt),
        .tick_en    (tick_en),
        .latch_mode (latch_mode),
        .pulse_len  (pulse_len),
        .out_on     (out_on)
    );
endmodule

// File: rtl/pdc_chk.sv
module pdc_chk #(
    parameter int SV_W = 8,
    localparam int PV_W = SV_W + 1
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   cnt_in,
    input logic                   clr_in,
    input logic [SV_W-1:0]        preset_val,
    input logic                   latch_mode,
    input logic                   clr_evt,
    input logic signed [PV_W-1:0] pv,
    input logic                   out_on
);
    localparam logic signed [PV_W-1:0] PV_MIN = {1'b1, {SV_W{1'b0}}};

    logic cnt_seen_q;
    logic step;

    always_ff @(posedge clk) begin
        if (rst) cnt_seen_q <= 1'b0;
        else     cnt_seen_q <= cnt_in;
    end

    assign step = cnt_in && !cnt_seen_q && !clr_in;

    a_r1_dec_by_one: assert property (@(posedge clk) disable iff (rst)
        (step && pv != PV_MIN) |=> (pv == $past(pv) - 1));

    a_r2_fire_at_zero: assert property (@(posedge clk) disable iff (rst)
        (step && pv == 1) |=> out_on);

    a_r8_rise_only_at_zero: assert property (@(posedge clk) disable iff (rst)
        $rose(out_on) |-> (pv == 0));

    a_r4_clear_effect: assert property (@(posedge clk) disable iff (rst)
        clr_evt |=> (!out_on && pv == signed'({1'b0, $past(preset_val)})));

    a_r5_inhibit_hold: assert property (@(posedge clk) disable iff (rst)
        clr_in |=> (pv == $past(pv) || pv == signed'({1'b0, $past(preset_val)})));

    a_r7_saturate: assert property (@(posedge clk) disable iff (rst)
        (step && pv == PV_MIN) |=> (pv == PV_MIN));

    a_r9_latched_holds: assert property (@(posedge clk) disable iff (rst)
        (out_on && latch_mode && !clr_evt && $stable(latch_mode)) |=> out_on);
endmodule

bind preset_down_counter pdc_chk #(.SV_W(SV_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .cnt_in     (cnt_in),
    .clr_in     (clr_in),
    .preset_val (preset_val),
    .latch_mode (latch_mode),
    .clr_evt    (clr_evt),
    .pv         (pv),
    .out_on     (out_on)
);

// File: tb/preset_down_counter_tb.sv
module preset_down_counter_tb;
    localparam int SV_W = 4;
    localparam int PW_W = 3;
    localparam int CW_W = 3;
    localparam int PV_W = SV_W + 1;
    localparam int PV_FLOOR = -(1 << SV_W);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tick_en = 1'b0;
    logic cnt_in = 1'b0;
    logic clr_in = 1'b0;
    logic [SV_W-1:0] preset_val = '0;
    logic latch_mode = 1'b1;
    logic [PW_W-1:0] pulse_len = '0;
    logic [CW_W-1:0] clr_min_len = 3'd1;
    logic signed [PV_W-1:0] pv;
    logic out_on;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    preset_down_counter #(.SV_W(SV_W), .PW_W(PW_W), .CW_W(CW_W)) u_dut (
        .clk(clk), .rst(rst), .tick_en(tick_en), .cnt_in(cnt_in),
        .clr_in(clr_in), .preset_val(preset_val), .latch_mode(latch_mode),
        .pulse_len(pulse_len), .clr_min_len(clr_min_len),
        .pv(pv), .out_on(out_on)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1;
        @(negedge clk);
        @(negedge clk); rst = 1'b0;
    endtask

    task automatic count_pulse();
        @(negedge clk); cnt_in = 1'b1;
        @(negedge clk); cnt_in = 1'b0;
    endtask

    task automatic tick_pulse();
        @(negedge clk); tick_en = 1'b1;
        @(negedge clk); tick_en = 1'b0;
    endtask

    task automatic hold_clear(input int edges);
        @(negedge clk); clr_in = 1'b1;
        repeat (edges) @(negedge clk);
        clr_in = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        // Sweep of every preset in held mode down to saturation
        latch_mode = 1'b1;
        for (int sv = 0; sv < (1 << SV_W); sv++) begin
            preset_val = SV_W'(sv);
            do_reset();
            check("R10 pv after reset", int'(pv), sv);
            check("R10 out after reset", int'(out_on), 0);
            for (int k = 1; k <= sv + 20; k++) begin
                int e;
                count_pulse();
                e = sv - k;
                if (e < PV_FLOOR) e = PV_FLOOR;
                check("R1 R3 R7 pv step", int'(pv), e);
                check("R2 R8 out level", int'(out_on), (sv >= 1 && k >= sv) ? 1 : 0);
            end
        end

        // Timed pulse lengths in ticks, plus no retrigger
        latch_mode = 1'b0;
        preset_val = 4'd2;
        for (int pw = 1; pw < (1 << PW_W); pw++) begin
            pulse_len = PW_W'(pw);
            do_reset();
            count_pulse();
            count_pulse();
            check("R2 timed out rises", int'(out_on), 1);
            for (int t = 1; t <= pw; t++) begin
                tick_pulse();
                check("R9 timed pulse length", int'(out_on), (t < pw) ? 1 : 0);
            end
            count_pulse();
            count_pulse();
            check("R8 no retrigger", int'(out_on), 0);
            check("R3 below zero", int'(pv), -2);
        end

        // Zero pulse length behaves as held
        pulse_len = '0;
        do_reset();
        count_pulse();
        count_pulse();
        repeat (6) tick_pulse();
        check("R9 zero length held", int'(out_on), 1);

        // Clear handling
        latch_mode = 1'b1;
        preset_val = 4'd5;
        clr_min_len = 3'd1;
        do_reset();
        repeat (3) count_pulse();
        check("R1 pv before clear", int'(pv), 2);
        @(negedge clk); clr_in = 1'b1;
        @(negedge clk);
        check("R4 reload on clear", int'(pv), 5);
        count_pulse();
        count_pulse();
        check("R5 counts ignored while clear", int'(pv), 5);
        @(negedge clk); cnt_in = 1'b1;
        @(negedge clk); clr_in = 1'b0;
        @(negedge clk);
        @(negedge clk); cnt_in = 1'b0;
        check("R5 stale edge not counted", int'(pv), 5);
        count_pulse();
        check("R5 resume after clear", int'(pv), 4);
        repeat (4) count_pulse();
        check("R2 out at zero", int'(out_on), 1);
        clr_min_len = 3'd3;
        hold_clear(2);
        check("R6 short clear pv", int'(pv), 0);
        check("R6 short clear out", int'(out_on), 1);
        hold_clear(3);
        check("R6 R4 full clear pv", int'(pv), 5);
        check("R4 full clear out", int'(out_on), 0);
        clr_min_len = 3'd0;
        count_pulse();
        check("R1 pv after clear", int'(pv), 4);
        hold_clear(1);
        check("R6 zero width as one", int'(pv), 5);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(4 * 150000);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule